// File: doc/BRIEF.md
# Tournament Branch Predictor Chooser

This block predicts the direction of a conditional branch by asking two component predictors and picking one answer. The global component keeps one shift register of recent branch outcomes and uses it to index a table of saturating counters. The local component keeps a short outcome history for each branch slot, chosen by low PC bits, and uses that history to index a second counter table. A third table of saturating counters, indexed by low PC bits, records which of the two components has done better for that branch. Its most significant bit selects the answer that goes out.

The predict port is combinational. The caller presents a PC and gets back the final direction, a flag for the component that was used, and both component answers. The caller keeps the component answers until the branch resolves. It then presents them on the update port with the PC and the real outcome. One update is applied on each clock edge where the update is valid.

Histories are not updated speculatively. Training uses the histories as they stand when the update arrives. Target addresses and recovery from wrong-path updates belong to other blocks.

Top module: `tourney_pred`

## Requirements
- R1: After synchronous reset, every chooser counter holds 1 (weakly local), every component counter holds 1 (weakly not-taken), and the global history and all local histories are zero. In that state, pred_use_global, pred_global, pred_local and pred_taken are all 0 for any PC.
- R2: Counters are 2-bit, and a counter predicts taken when its MSB is 1. pred_taken equals pred_global when pred_use_global is 1, and equals pred_local otherwise. pred_use_global is the MSB of the chooser counter for pred_pc.
- R3: The chooser counter is selected by pred_pc[5:0] (update: upd_pc[5:0]). Two PCs that differ only above bit 5 share one chooser counter.
- R4: On a valid update where upd_global_pred equals upd_taken and upd_local_pred does not, the chooser counter rises by one. When only the local answer was right, it falls by one. It saturates at 3 and at 0.
- R5: On a valid update where upd_global_pred equals upd_local_pred, the chooser counter keeps its value.
- R6: The global counter table has 64 entries indexed by the 6-bit global history. On every valid update, the entry at the current history steps toward upd_taken (up if taken, down if not), with saturation.
- R7: On every valid update, the global history shifts left by one and takes upd_taken into bit 0.
- R8: The local history table has 64 slots of 5 bits each, indexed by PC bits [5:0]. The slot's history indexes a 32-entry local counter table. On every valid update, whichever component was chosen, the counter at upd_pc's current history steps toward upd_taken. That slot's history then shifts left with upd_taken entering bit 0.
- R9: While upd_valid is 0, no counter or history changes, whatever the other update inputs carry.
- R10: The predict outputs are combinational in pred_pc and the stored state. An update applied at one clock edge is visible on the predict outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_taken | output | 1 | Final direction prediction |
| pred_use_global | output | 1 | 1 when the global component supplied pred_taken |
| pred_global | output | 1 | Global component's prediction |
| pred_local | output | 1 | Local component's prediction |
| upd_valid | input | 1 | Apply an update on this clock edge |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_global_pred | input | 1 | Global component's prediction saved at predict time |
| upd_local_pred | input | 1 | Local component's prediction saved at predict time |

## Verification
The bench trains one chooser counter up to its ceiling and back down. A chooser that wrapped at saturation, or that moved when both components agreed, would flip the selected source at the wrong update. It reads the trained PC and an alias that differs only above the index bits. An index built from the wrong PC bits would show the alias untrained. Long random and pattern-driven runs compare every output on every cycle against a behavioural model. That catches a history shifted the wrong way, training applied only to the chosen component, and a table indexed by the post-update history instead of the current one. Idle cycles with busy update inputs confirm that nothing trains while upd_valid is low.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_TOP  = '1;
    localparam ctr_t CTR_WEAK = ctr_t'((1 << (CTR_W - 1)) - 1);

    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;

    typedef struct packed {
        logic taken;
        logic glob;
        logic loc;
    } upd_bits_t;

    function automatic ctr_t sat_step(input ctr_t cur, input logic up);
        ctr_t res;
        if (up) begin
            res = (cur == CTR_TOP) ? cur : cur + ctr_t'(1);
        end else begin
            res = (cur == '0) ? cur : cur - ctr_t'(1);
        end
        return res;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int           IDX_W   = 6,
    parameter tp_pkg::ctr_t RST_CTR = tp_pkg::CTR_WEAK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hi,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    tp_pkg::ctr_t mem [DEPTH];
    tp_pkg::ctr_t nxt;

    always_comb begin
        nxt   = tp_pkg::sat_step(mem[wr_idx], wr_up);
        rd_hi = mem[rd_idx][tp_pkg::CTR_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= RST_CTR;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= nxt;
        end
    end
endmodule

// File: rtl/tp_lhist_table.sv
module tp_lhist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  up_idx,
    output logic [HIST_W-1:0] up_hist,
    input  logic              up_en,
    input  logic              up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] slot [DEPTH];

    always_comb begin
        rd_hist = slot[rd_idx];
        up_hist = slot[up_idx];
    end

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
                end else if (up_en) begin
                    slot[up_idx] <= up_bit;
                end
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
                end else if (up_en) begin
                    slot[up_idx] <= {up_hist[HIST_W-2:0], up_bit};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              in_bit,
    output logic [HIST_W-1:0] hist
);
    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= in_bit;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= {hist[HIST_W-2:0], in_bit};
            end
        end
    endgenerate
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
    parameter int PC_W        = 32,
    parameter int SEL_IDX_W   = 6,
    parameter int GHIST_W     = 6,
    parameter int LSLOT_IDX_W = 6,
    parameter int LHIST_W     = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_use_global,
    output logic            pred_global,
    output logic            pred_local,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_global_pred,
    input  logic            upd_local_pred
);
    import tp_pkg::*;

    upd_bits_t          ub;
    src_e               src;
    logic               sel_hi;
    logic               unused_pc_bits;
    logic [GHIST_W-1:0] ghist_q;
    logic [LHIST_W-1:0] lh_rd;
    logic [LHIST_W-1:0] lh_up;

    assign ub             = '{taken: upd_taken, glob: upd_global_pred, loc: upd_local_pred};
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    // Chooser: moves only when exactly one component was right.
    tp_ctr_table #(.IDX_W(SEL_IDX_W), .RST_CTR(CTR_WEAK)) u_chooser (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (pred_pc[SEL_IDX_W-1:0]),
        .rd_hi  (sel_hi),
        .wr_en  (upd_valid && (ub.glob != ub.loc)),
        .wr_idx (upd_pc[SEL_IDX_W-1:0]),
        .wr_up  (ub.glob == ub.taken)
    );

    tp_ghist #(.HIST_W(GHIST_W)) u_ghist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .in_bit   (ub.taken),
        .hist     (ghist_q)
    );

    // Global component: trained at the history current at update time.
    tp_ctr_table #(.IDX_W(GHIST_W), .RST_CTR(CTR_WEAK)) u_gtab (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ghist_q),
        .rd_hi  (pred_global),
        .wr_en  (upd_valid),
        .wr_idx (ghist_q),
        .wr_up  (ub.taken)
    );

    tp_lhist_table #(.IDX_W(LSLOT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (pred_pc[LSLOT_IDX_W-1:0]),
        .rd_hist (lh_rd),
        .up_idx  (upd_pc[LSLOT_IDX_W-1:0]),
        .up_hist (lh_up),
        .up_en   (upd_valid),
        .up_bit  (ub.taken)
    );

    tp_ctr_table #(.IDX_W(LHIST_W), .RST_CTR(CTR_WEAK)) u_ltab (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (lh_rd),
        .rd_hi  (pred_local),
        .wr_en  (upd_valid),
        .wr_idx (lh_up),
        .wr_up  (ub.taken)
    );

    always_comb begin
        src             = src_e'(sel_hi);
        pred_use_global = (src == SRC_GLOBAL);
        pred_taken      = (src == SRC_GLOBAL) ? pred_global : pred_local;
    end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    pred_pc,
    input logic               pred_taken,
    input logic               pred_use_global,
    input logic               pred_global,
    input logic               pred_local,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic               upd_taken,
    input logic               upd_global_pred,
    input logic               upd_local_pred,
    input logic [GHIST_W-1:0] ghist
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!pred_use_global && ghist == '0));

    p_pick_r2: assert property (@(posedge clk) disable iff (rst)
        pred_taken == (pred_use_global ? pred_global : pred_local));

    p_sat_global_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_global_pred == upd_taken && upd_local_pred != upd_taken
         && pred_use_global && pred_pc == upd_pc)
        |=> (pred_pc != $past(pred_pc) || pred_use_global));

    p_agree_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_global_pred == upd_local_pred && pred_pc == upd_pc)
        |=> (pred_pc != $past(pred_pc) || pred_use_global == $past(pred_use_global)));

    p_ghist_shift_r7: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghist == {$past(ghist), $past(upd_taken)}[GHIST_W-1:0]);

    p_idle_hist_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghist));

    p_idle_pred_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> (pred_pc != $past(pred_pc)
                        || (pred_taken == $past(pred_taken)
                            && pred_use_global == $past(pred_use_global))));
endmodule

bind tourney_pred tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .pred_pc         (pred_pc),
    .pred_taken      (pred_taken),
    .pred_use_global (pred_use_global),
    .pred_global     (pred_global),
    .pred_local      (pred_local),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_taken       (upd_taken),
    .upd_global_pred (upd_global_pred),
    .upd_local_pred  (upd_local_pred),
    .ghist           (ghist_q)
);

// File: tb/tourney_pred_tb_top.sv
module tourney_pred_tb_top;
    localparam int PC_W    = 32;
    localparam int SEL_N   = 64;
    localparam int GH_N    = 64;
    localparam int LS_N    = 64;
    localparam int LC_N    = 32;
    localparam int CMAX    = 3;
    localparam int CRST    = 1;
    localparam int WD_LIMIT = 150000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken, pred_use_global, pred_global, pred_local;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            upd_global_pred = 1'b0;
    logic            upd_local_pred = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int mch [SEL_N];
    int mgc [GH_N];
    int mlh [LS_N];
    int mlc [LC_N];
    int mgh;

    tourney_pred dut_i (
        .clk             (clk),
        .rst             (rst),
        .pred_pc         (pred_pc),
        .pred_taken      (pred_taken),
        .pred_use_global (pred_use_global),
        .pred_global     (pred_global),
        .pred_local      (pred_local),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_global_pred (upd_global_pred),
        .upd_local_pred  (upd_local_pred)
    );

    always #5 clk = ~clk;

    function automatic bit m_gp();
        return mgc[mgh] >= 2;
    endfunction

    function automatic bit m_lp(input logic [PC_W-1:0] pc);
        return mlc[mlh[int'(pc) & (LS_N - 1)]] >= 2;
    endfunction

    function automatic bit m_ug(input logic [PC_W-1:0] pc);
        return mch[int'(pc) & (SEL_N - 1)] >= 2;
    endfunction

    function automatic int sat(input int v, input bit up);
        if (up) return (v == CMAX) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < SEL_N; i++) mch[i] = CRST;
        for (int i = 0; i < GH_N; i++)  mgc[i] = CRST;
        for (int i = 0; i < LS_N; i++)  mlh[i] = 0;
        for (int i = 0; i < LC_N; i++)  mlc[i] = CRST;
        mgh = 0;
    endtask

    task automatic model_update();
        int ci, si;
        if (!upd_valid) return;
        ci = int'(upd_pc) & (SEL_N - 1);
        si = int'(upd_pc) & (LS_N - 1);
        if (upd_global_pred != upd_local_pred)
            mch[ci] = sat(mch[ci], upd_global_pred == upd_taken);
        mgc[mgh]      = sat(mgc[mgh], upd_taken);
        mlc[mlh[si]]  = sat(mlc[mlh[si]], upd_taken);
        mlh[si]       = ((mlh[si] << 1) | int'(upd_taken)) & (LC_N - 1);
        mgh           = ((mgh << 1) | int'(upd_taken)) & (GH_N - 1);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (pc=%0h)", tag, act, exp, pred_pc);
        end
    endtask

    task automatic compare();
        bit ug, gp, lp;
        ug = m_ug(pred_pc);
        gp = m_gp();
        lp = m_lp(pred_pc);
        chk("R3 R4 R5 R10 chooser source", pred_use_global, ug);
        chk("R6 R7 global component", pred_global, gp);
        chk("R8 local component", pred_local, lp);
        chk("R2 final direction", pred_taken, ug ? gp : lp);
    endtask

    // Inputs were set at a falling edge; compare, apply model, advance one cycle.
    task automatic cycle();
        #1;
        compare();
        model_update();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_upd(input bit v, input logic [PC_W-1:0] pc, input bit t,
                           input bit g, input bit l);
        upd_valid = v; upd_pc = pc; upd_taken = t;
        upd_global_pred = g; upd_local_pred = l;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [PC_W-1:0] pa;
        bit snap_ug, snap_t;
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        pred_pc = 32'h0000_1234;
        #1;
        chk("R1 reset source", pred_use_global, 1'b0);
        chk("R1 reset global", pred_global, 1'b0);
        chk("R1 reset local", pred_local, 1'b0);
        chk("R1 reset taken", pred_taken, 1'b0);

        // R4: drive chooser of pa to the global ceiling and hold it there
        pa = 32'h0000_0105;
        pred_pc = pa;
        for (int i = 0; i < 5; i++) begin
            set_upd(1'b1, pa, 1'b1, 1'b1, 1'b0);
            cycle();
        end
        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R4 saturated toward global", pred_use_global, 1'b1);

        // R5: agreeing components leave the chooser alone
        for (int i = 0; i < 3; i++) begin
            set_upd(1'b1, pa, i[0], 1'b0, 1'b0);
            cycle();
        end
        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R5 agreement holds chooser", pred_use_global, 1'b1);

        // R3: alias above the index bits shares the chooser; neighbour does not
        pred_pc = pa + 32'h40;
        #1;
        chk("R3 alias shares chooser", pred_use_global, 1'b1);
        pred_pc = pa + 32'h1;
        #1;
        chk("R3 neighbour untouched", pred_use_global, 1'b0);

        // R4: one local win keeps global (3->2), second flips to local (2->1)
        pred_pc = pa;
        set_upd(1'b1, pa, 1'b0, 1'b1, 1'b0);
        cycle();
        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R4 step down stays global", pred_use_global, 1'b1);
        set_upd(1'b1, pa, 1'b0, 1'b1, 1'b0);
        cycle();
        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R4 step down to local", pred_use_global, 1'b0);
        for (int i = 0; i < 3; i++) begin
            set_upd(1'b1, pa, 1'b0, 1'b1, 1'b0);
            cycle();
        end

        // R9: busy update inputs with upd_valid low change nothing
        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        #1;
        snap_ug = pred_use_global;
        snap_t  = pred_taken;
        for (int i = 0; i < 6; i++) begin
            set_upd(1'b0, pa, i[0], i[1], ~i[0]);
            cycle();
        end
        #1;
        chk("R9 idle keeps chooser", pred_use_global, snap_ug);
        chk("R9 idle keeps direction", pred_taken, snap_t);

        // Random updates, unrelated predict PCs
        for (int i = 0; i < 4000; i++) begin
            pred_pc = {$urandom} & 32'h0000_00ff;
            set_upd(($urandom % 4) != 0, {$urandom} & 32'h0000_00ff,
                    $urandom % 2, $urandom % 2, $urandom % 2);
            cycle();
        end

        // Pattern-driven run with component answers fed back from the model
        for (int i = 0; i < 6000; i++) begin
            logic [PC_W-1:0] pc;
            bit t;
            int b;
            b  = i % 4;
            pc = 32'h0000_0200 + 32'(b * 4);
            case (b)
                0: t = ((i / 4) % 4) != 3;
                1: t = ((i / 4) % 2) == 0;
                2: t = ((i / 4) % 4) != 3;
                default: t = $urandom % 2;
            endcase
            pred_pc = pc;
            set_upd(1'b1, pc, t, m_gp(), m_lp(pc));
            cycle();
        end

        set_upd(1'b0, '0, 1'b0, 1'b0, 1'b0);
        cycle();
        finish_run();
    end
endmodule